// File: doc/BRIEF.md
# Indexed Two-Byte Accumulator CPU Core

This block is a small 8-bit processor core. It has two 9-bit working registers, the accumulator A and the index register X. In each register, bit 8 is a carry flag and bits 7:0 are the value. The core addresses a 13-bit byte space. Every instruction is two bytes long. The first byte carries a 3-bit opcode in bits 7:5 and address bits 12:8 in bits 4:0. The second byte carries address bits 7:0. The core can NOR or ADD a memory byte into A or X, store the low byte of A or X, jump when A's carry is clear, and jump when A's low byte is nonzero. Instructions that name A are indexed: the low byte of X is added to their operand address.

The core steps through three phases per instruction: opcode fetch, address fetch and execute. A taken jump skips the execute phase. The core talks to an external byte memory through an address bus, a read-data bus, a write-data bus and two strobes. The strobes are qualified by the level of the clock, so the memory sees a read or write pulse only in the low half of each cycle. The memory answers with fixed timing, so there is no back-pressure. The read data must be valid before the next rising edge for the address that was presented in that cycle. Nothing streams across this interface.

Top module: `idx_cpu_core`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) sets the address bus to 0, clears A, X and the phase, and leaves the strobes at output enable 1 and write enable 0 while the clock is low.
- R2: While clk is high, mem_oe and mem_we are both 0.
- R3: While clk is low, exactly one strobe is 1. mem_we is 1, mem_oe is 0 and mem_wdata carries the low byte of the selected register only in the execute phase of a store. In every other case mem_oe is 1 and mem_wdata is 0.
- R4: In the opcode-fetch phase, the core captures the opcode and high address bits and records the return address as the current address + 2 (mod 8192). The address bus then advances by 1 (mod 8192), so 0x1FFF is followed by 0x0000.
- R5: In the address-fetch phase, the operand address is {high bits, second byte}. When opcode bit 2 is 0, X bits 7:0 are added, and the sum wraps modulo 8192.
- R6: Opcode bits 1:0 select the operation: 00 NOR, 01 ADD, 10 store, 11 jump. Opcode bit 2 selects X (1) or A (0). For a jump, bit 2 selects jump-if-nonzero (1) or jump-if-carry-clear (0).
- R7: ADD sets the selected register to (register bits 7:0) + byte. The 9-bit sum includes the carry out in bit 8.
- R8: NOR sets the selected register's bits 7:0 to the inverse of (bits 7:0 OR byte) and leaves its carry bit unchanged.
- R9: A jump-if-carry-clear is taken when A's carry is 0. A jump-if-nonzero is taken when A bits 7:0 are nonzero. A taken jump fetches its next opcode from the formed address in the cycle after address fetch. A jump that is not taken spends one execute cycle, clears A's carry, and resumes at the return address.
- R10: After every execute phase, the next opcode fetch is from the return address. A store changes neither A nor X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its low half qualifies the memory strobes |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rdata | input | 8 | Byte read from memory at mem_addr |
| mem_addr | output | 13 | Registered memory address |
| mem_wdata | output | 8 | Store data, 0 when not storing |
| mem_oe | output | 1 | Read strobe, active in clock-low half |
| mem_we | output | 1 | Write strobe, active in clock-low half of a store |

## Verification
The address bus is registered, so the address that a phase computes appears 1 ns after the rising edge that ends the phase. The bench checks it there, once per cycle. The strobes depend on the clock level. They are checked 1 ns after each rising edge, where both must be 0, and again in the following low half, where the phase just entered decides them. A behavioural model advances on the same edges using the read byte presented in the previous cycle. The model commits memory writes in the low half in which mem_we is seen. As a result, results of arithmetic that only show through later stores and branch paths are compared at exactly the cycle they reach the pins.

// File: rtl/idx_cpu_pkg.sv
package idx_cpu_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_ADDR  = 2'd1,
    PH_EXEC  = 2'd2
  } phase_e;

  // Encoded in opcode bits 1:0
  typedef enum logic [1:0] {
    FN_NOR   = 2'd0,
    FN_ADD   = 2'd1,
    FN_STORE = 2'd2,
    FN_JUMP  = 2'd3
  } fn_e;

  localparam int OPC_W = 3;
  localparam int NREG  = 2;   // index 0 = A, index 1 = X

endpackage

// File: rtl/idx_cpu_alu.sv
module idx_cpu_alu
  import idx_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  fn_e               fn,
  input  logic [DATA_W:0]   reg_in,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W:0]   result
);

  always_comb begin
    unique case (fn)
      FN_NOR:  result = {reg_in[DATA_W], ~(reg_in[DATA_W-1:0] | operand)};
      FN_ADD:  result = {1'b0, reg_in[DATA_W-1:0]} + {1'b0, operand};
      default: result = reg_in;
    endcase
  end

endmodule

// File: rtl/idx_cpu_agu.sv
module idx_cpu_agu #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-DATA_W-1:0] hi_bits,
  input  logic [DATA_W-1:0]        lo_bits,
  input  logic [DATA_W-1:0]        index,
  input  logic                     use_index,
  output logic [ADDR_W-1:0]        addr
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offs;

  always_comb begin
    base = {hi_bits, lo_bits};
    offs = use_index ? ADDR_W'(index) : '0;
    addr = base + offs;
  end

endmodule

// File: rtl/idx_cpu_strobes.sv
module idx_cpu_strobes #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              storing,
  input  logic [DATA_W-1:0] store_byte,
  output logic              oe,
  output logic              we,
  output logic [DATA_W-1:0] wdata
);

  always_comb begin
    oe    = !clk && !storing;
    we    = !clk && storing;
    wdata = storing ? store_byte : '0;
  end

endmodule

// File: rtl/idx_cpu_core.sv
module idx_cpu_core
  import idx_cpu_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_oe,
  output logic              mem_we
);

  localparam int HI_W = ADDR_W - DATA_W;
  localparam int RW   = DATA_W + 1;
  localparam int CY   = DATA_W;      // carry bit position

  phase_e             phase;
  logic [OPC_W-1:0]   opc_q;
  logic [HI_W-1:0]    hi_q;
  logic [ADDR_W-1:0]  adr_q;
  logic [ADDR_W-1:0]  ret_q;
  logic [RW-1:0]      regs_q [NREG];
  logic [RW-1:0]      alu_res [NREG];

  fn_e                fn;
  logic               sel;
  logic               taken;
  logic               storing;
  logic [ADDR_W-1:0]  formed;

  assign fn  = fn_e'(opc_q[1:0]);
  assign sel = opc_q[2];

  // One arithmetic unit per working register
  for (genvar g = 0; g < NREG; g++) begin : g_alu
    idx_cpu_alu #(.DATA_W(DATA_W)) u_alu (
      .fn      (fn),
      .reg_in  (regs_q[g]),
      .operand (mem_rdata),
      .result  (alu_res[g])
    );
  end

  idx_cpu_agu #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_agu (
    .hi_bits   (hi_q),
    .lo_bits   (mem_rdata),
    .index     (regs_q[1][DATA_W-1:0]),
    .use_index (!sel),
    .addr      (formed)
  );

  // Branch condition always inspects the accumulator
  always_comb begin
    if (sel) taken = |regs_q[0][DATA_W-1:0];
    else     taken = !regs_q[0][CY];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_FETCH;
      opc_q <= '0;
      hi_q  <= '0;
      adr_q <= '0;
      ret_q <= '0;
    end else begin
      unique case (phase)
        PH_FETCH: begin
          opc_q <= mem_rdata[DATA_W-1 -: OPC_W];
          hi_q  <= mem_rdata[HI_W-1:0];
          ret_q <= adr_q + ADDR_W'(2);
          adr_q <= adr_q + ADDR_W'(1);
          phase <= PH_ADDR;
        end
        PH_ADDR: begin
          adr_q <= formed;
          phase <= (fn == FN_JUMP && taken) ? PH_FETCH : PH_EXEC;
        end
        PH_EXEC: begin
          adr_q <= ret_q;
          phase <= PH_FETCH;
        end
        default: phase <= PH_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (phase == PH_EXEC) begin
      for (int i = 0; i < NREG; i++) begin
        if ((fn == FN_NOR || fn == FN_ADD) && int'(sel) == i)
          regs_q[i] <= alu_res[i];
      end
      // Only a jump that was not taken reaches execute
      if (fn == FN_JUMP) regs_q[0][CY] <= 1'b0;
    end
  end

  assign storing  = (phase == PH_EXEC) && (fn == FN_STORE);
  assign mem_addr = adr_q;

  idx_cpu_strobes #(.DATA_W(DATA_W)) u_strb (
    .clk        (clk),
    .storing    (storing),
    .store_byte (regs_q[sel][DATA_W-1:0]),
    .oe         (mem_oe),
    .we         (mem_we),
    .wdata      (mem_wdata)
  );

endmodule

// File: rtl/idx_cpu_chk.sv
module idx_cpu_chk
  import idx_cpu_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input phase_e            phase,
  input logic [OPC_W-1:0]  opc,
  input logic              mem_oe,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W:0]   a_q,
  input logic [DATA_W:0]   x_q
);

  assert_strobes_idle_high_R2: assert property (@(negedge clk) disable iff (!rst_n)
    !mem_oe && !mem_we);

  assert_one_strobe_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_oe, mem_we}) == 1);

  assert_write_only_in_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase == PH_EXEC && opc[1:0] == 2'b10));

  assert_fetch_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_FETCH |=> (phase == PH_ADDR && mem_addr == $past(mem_addr) + ADDR_W'(1)));

  assert_carry_clear_jump_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR && opc == 3'b011 && !a_q[DATA_W]) |=> phase == PH_FETCH);

  assert_exec_then_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_EXEC |=> phase == PH_FETCH);

  assert_store_keeps_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && opc[1:0] == 2'b10) |=> ($stable(a_q) && $stable(x_q)));

endmodule

bind idx_cpu_core idx_cpu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phase    (phase),
  .opc      (opc_q),
  .mem_oe   (mem_oe),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .a_q      (regs_q[0]),
  .x_q      (regs_q[1])
);

// File: tb/idx_cpu_core_tb.sv
module idx_cpu_core_tb;

  localparam int AW    = 13;
  localparam int DW    = 8;
  localparam int AMASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_oe;
  logic          mem_we;

  idx_cpu_core u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_oe    (mem_oe),
    .mem_we    (mem_we)
  );

  always #5 clk = ~clk;   // 100 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] mem [int];
  int wr_addr [$];
  int wr_data [$];

  // reference model state
  int m_st, m_op, m_hi, m_adr, m_ret, m_a, m_x;

  function automatic int rd(int a);
    if (mem.exists(a)) return int'(mem[a]);
    return 0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_st = 0; m_op = 0; m_hi = 0; m_adr = 0; m_ret = 0; m_a = 0; m_x = 0;
  endfunction

  function automatic void model_step(int d);
    int f;
    bit tk;
    case (m_st)
      0: begin
        m_op  = (d >> 5) & 7;
        m_hi  = d & 31;
        m_ret = (m_adr + 2) & AMASK;
        m_adr = (m_adr + 1) & AMASK;
        m_st  = 1;
      end
      1: begin
        f = (m_hi << 8) | d;
        if ((m_op & 4) == 0) f = f + (m_x & 255);
        m_adr = f & AMASK;
        if ((m_op & 3) == 3) begin
          tk   = (m_op & 4) != 0 ? ((m_a & 255) != 0) : ((m_a & 256) == 0);
          m_st = tk ? 0 : 2;
        end else m_st = 2;
      end
      default: begin
        case (m_op)
          0: m_a = (m_a & 256) | (~(m_a | d) & 255);
          1: m_a = ((m_a & 255) + d) & 511;
          4: m_x = (m_x & 256) | (~(m_x | d) & 255);
          5: m_x = ((m_x & 255) + d) & 511;
          3, 7: m_a = m_a & 255;
          default: ;
        endcase
        m_adr = m_ret;
        m_st  = 0;
      end
    endcase
  endfunction

  task automatic cycle();
    int d;
    int prev;
    bit store;
    int expw;
    string tag;
    d = int'(mem_rdata);
    @(posedge clk);
    prev = m_st;
    if (!rst_n) model_reset();
    else model_step(d);
    #1;
    tag = !rst_n ? "R1" : (prev == 0 ? "R4" : (prev == 1 ? "R5" : "R10"));
    chk(int'(mem_addr) == m_adr, tag, "mem_addr", int'(mem_addr), m_adr);
    chk(!mem_oe && !mem_we, "R2", "strobes clk high", int'({mem_oe, mem_we}), 0);
    mem_rdata = rd(m_adr) & 8'hFF;
    #5;
    store = (m_st == 2) && ((m_op & 3) == 2);
    expw  = store ? (((m_op & 4) != 0 ? m_x : m_a) & 255) : 0;
    chk(mem_oe == !store && mem_we == store, rst_n ? "R3" : "R1",
        "strobes clk low", int'({mem_oe, mem_we}), store ? 1 : 2);
    chk(int'(mem_wdata) == expw, "R3", "mem_wdata", int'(mem_wdata), expw);
    if (mem_we) begin
      mem[int'(mem_addr)] = mem_wdata;
      wr_addr.push_back(int'(mem_addr));
      wr_data.push_back(int'(mem_wdata));
    end
  endtask

  task automatic put(int a, int b0, int b1);
    mem[a]     = b0[7:0];
    mem[a + 1] = b1[7:0];
  endtask

  initial begin
    // operand data
    mem[32'h100] = 8'hF0; mem[32'h101] = 8'h20; mem[32'h102] = 8'h01;
    mem[32'h103] = 8'hFF; mem[32'h107] = 8'hFF; mem[32'h108] = 8'hFE;
    // program
    put(32'h00, 8'h21, 8'h00);  // ADD A [100]      -> A=0F0
    put(32'h02, 8'h21, 8'h01);  // ADD A [101]      -> A=110 (R7 carry)
    put(32'h04, 8'h01, 8'h04);  // NOR A [104]      -> A=1EF (R8 keeps carry)
    put(32'h06, 8'h60, 8'h40);  // JCC not taken    -> A=0EF (R9)
    put(32'h08, 8'hA1, 8'h02);  // ADD X [102]      -> X=001
    put(32'h0A, 8'h42, 8'h00);  // STA [200]+X      -> [201]=EF
    put(32'h0C, 8'h01, 8'h03);  // NOR A [103]+X    -> A=010
    put(32'h0E, 8'hC2, 8'h02);  // STX [202]        -> [202]=01
    put(32'h10, 8'h60, 8'h20);  // JCC taken        -> 021
    put(32'h21, 8'hE0, 8'h30);  // JNZ taken        -> 030
    put(32'h30, 8'h01, 8'h06);  // NOR A [106]+X    -> A=000
    put(32'h32, 8'hE0, 8'h40);  // JNZ not taken
    put(32'h34, 8'hA1, 8'h03);  // ADD X [103]      -> X=100
    put(32'h36, 8'h81, 8'h08);  // NOR X [108]      -> X=101
    put(32'h38, 8'h7F, 8'hFE);  // JCC 1FFE+X       -> 1FFF
    mem[32'h1FFF] = 8'hC2;      // STX, low byte from 0000 after wrap -> [221]=01

    model_reset();
    rst_n = 1'b0;
    repeat (3) cycle();
    // R1: reset state at the ports
    chk(mem_addr == '0, "R1", "reset addr", int'(mem_addr), 0);
    chk(mem_oe && !mem_we, "R1", "reset strobes", int'({mem_oe, mem_we}), 2);
    rst_n = 1'b1;
    repeat (60) cycle();

    chk(wr_addr.size() >= 3, "R10", "store count", wr_addr.size(), 3);
    if (wr_addr.size() >= 3) begin
      // R8: stored A reflects NOR keeping carry so the JCC fell through
      chk(wr_addr[0] == 'h201 && wr_data[0] == 'hEF, "R8", "first store",
          (wr_addr[0] << 8) | wr_data[0], 'h201EF);
      // R6: store of X without indexing
      chk(wr_addr[1] == 'h202 && wr_data[1] == 'h01, "R6", "second store",
          (wr_addr[1] << 8) | wr_data[1], 'h20201);
      // R9 / R5: reached through taken jumps and an indexed jump target
      chk(wr_addr[2] == 'h221 && wr_data[2] == 'h01, "R9", "third store",
          (wr_addr[2] << 8) | wr_data[2], 'h22101);
    end

    // mid-run reset
    rst_n = 1'b0;
    repeat (2) cycle();
    chk(mem_addr == '0, "R1", "re-reset addr", int'(mem_addr), 0);
    rst_n = 1'b1;
    repeat (20) cycle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule